// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Port

This block keeps the configuration word of a frequency synthesizer. The word has three fields: a 9-bit loop divide value, a 2-bit output divider select and a 3-bit test select. At power-up the word is taken from parallel pins. Later it can be rewritten through a three-wire serial port, which has a clock, a data line and a load strobe.

The serial port feeds a 14-bit shift register. Two load paths write the held configuration, and each behaves like a level-sensitive latch. The parallel path is open while its strobe is low. The serial path is open while its strobe is high. All of this is modelled synchronously in a fast system clock domain. The serial clock, the two strobes, the serial data and the parallel pins pass through a two-flop synchronizer. Edges of the serial clock are then found in the system domain.

The parallel path wins over the serial path. Holding the parallel strobe low also clears the test select. The oldest bit in the shift register is brought out so that a downstream test multiplexer can route it.

Top module: `clk_cfg_port`

## Requirements
- R1: Each rising edge of ser_clk_i shifts the 14-bit register by one place and takes in ser_data_i. With no rising edge the register keeps its contents.
- R2: Serial words are sent MSB first. After 14 shifts, the three bits sent first form t_sel_o (first bit = t_sel_o[2]). The next two bits form n_sel_o (MSB first). The last nine bits form m_div_o (MSB first).
- R3: While ser_load_i is high and par_load_n_i is high, the outputs follow the shift register. When ser_load_i falls, the value is held, and later shifts do not change the outputs.
- R4: While par_load_n_i is low, m_div_o and n_sel_o follow par_m_i and par_n_i. When par_load_n_i rises, the value is held, and later changes on the pins do not change the outputs.
- R5: While par_load_n_i is low, ser_load_i has no effect. The outputs keep showing the parallel pins.
- R6: t_sel_o is 000 whenever par_load_n_i is low. This holds even if the serial path had set it to another value.
- R7: last_bit_o is bit 13 of the shift register, which is the oldest bit. After a full 14-bit word it equals the first bit sent.
- R8: While rst_ni is low, the block acts as if the parallel load were active with its pins pulled up: m_div_o = 0x1FF, n_sel_o = 2'b11, t_sel_o = 000.
- R9: A change on the inputs shows at the outputs within 4 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than ser_clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_data_i | input | 1 | Serial data, sampled on the ser_clk_i rising edge |
| ser_load_i | input | 1 | Serial load strobe; the serial path is open while high |
| par_load_n_i | input | 1 | Parallel load strobe; the parallel path is open while low |
| par_m_i | input | 9 | Parallel loop divide value |
| par_n_i | input | 2 | Parallel output divider select |
| m_div_o | output | 9 | Held loop divide value |
| n_sel_o | output | 2 | Held output divider select |
| t_sel_o | output | 3 | Held test select |
| last_bit_o | output | 1 | Oldest shift register bit |

## Verification
The assertions assume that ser_data_i is stable when a ser_clk_i edge is synchronized. They also assume that each level of ser_clk_i and of the strobes lasts longer than the synchronizer, so that no edge is lost or merged.

The bench keeps each serial clock phase, and each data and pin change, for four system clocks or more. It samples outputs only after a settle interval. Random words, drawn from a fixed seed, are mixed with directed cases on priority, latch transparency and the test-select clear.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int unsigned M_W  = 9;
  localparam int unsigned N_W  = 2;
  localparam int unsigned T_W  = 3;
  localparam int unsigned SR_W = T_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  localparam cfg_t CFG_RST = '{t: '0, n: '1, m: '1};
endpackage

// File: rtl/clk_cfg_sync.sv
module clk_cfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_cfg_shift.sv
module clk_cfg_shift #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], din_i};
  end

  assign sr_o = sr_q;

  AST_SHIFT_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sr_q[W-1:1] == $past(sr_q[W-2:0]))); // R1
  AST_SHIFT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q)); // R1
endmodule

// File: rtl/clk_cfg_latch.sv
module clk_cfg_latch
  import clk_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_open_i,
  input  logic           ser_open_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  cfg_t           ser_cfg_i,
  output cfg_t           cfg_o
);
  cfg_t cfg_q;

  // parallel path wins; it also clears the test select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (par_open_i) begin
      cfg_q.m <= par_m_i;
      cfg_q.n <= par_n_i;
      cfg_q.t <= '0;
    end else if (ser_open_i) begin
      cfg_q <= ser_cfg_i;
    end
  end

  assign cfg_o = cfg_q;

  AST_PAR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_open_i |=> (cfg_q.m == $past(par_m_i) && cfg_q.n == $past(par_n_i))); // R4
  AST_T_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_open_i |=> (cfg_q.t == '0)); // R6
  AST_SER_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_open_i && ser_open_i) |=> (cfg_q == $past(ser_cfg_i))); // R3
  AST_HOLD_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_open_i && !ser_open_i) |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/clk_cfg_port.sv
module clk_cfg_port
  import clk_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           par_load_n_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  output logic [M_W-1:0] m_div_o,
  output logic [N_W-1:0] n_sel_o,
  output logic [T_W-1:0] t_sel_o,
  output logic           last_bit_o
);
  localparam int unsigned IN_W = 4 + M_W + N_W;
  // bit map: 0 par_load_n, 1 ser_load, 2 ser_clk, 3 ser_data, then m, n
  localparam logic [IN_W-1:0] IN_RST = {{(M_W+N_W){1'b1}}, 4'b0000};

  logic [IN_W-1:0] in_s;
  logic            ser_clk_q;
  logic            ser_rise;
  logic [SR_W-1:0] sr;
  cfg_t            cfg;

  clk_cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({par_n_i, par_m_i, ser_data_i, ser_clk_i, ser_load_i, par_load_n_i}),
    .q_o   (in_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ser_clk_q <= 1'b0;
    else         ser_clk_q <= in_s[2];
  end

  assign ser_rise = in_s[2] & ~ser_clk_q;

  clk_cfg_shift #(.W(SR_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(ser_rise),
    .din_i  (in_s[3]),
    .sr_o   (sr)
  );

  clk_cfg_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .par_open_i(~in_s[0]),
    .ser_open_i(in_s[1]),
    .par_m_i   (in_s[4 +: M_W]),
    .par_n_i   (in_s[4+M_W +: N_W]),
    .ser_cfg_i (cfg_t'(sr)),
    .cfg_o     (cfg)
  );

  assign m_div_o    = cfg.m;
  assign n_sel_o    = cfg.n;
  assign t_sel_o    = cfg.t;
  assign last_bit_o = sr[SR_W-1];

  AST_LAST_BIT_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_rise |=> (last_bit_o == $past(sr[SR_W-2]))); // R7
  AST_PAR_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_s[0] && in_s[1]) |=> (t_sel_o == '0)); // R5
endmodule

// File: tb/clk_cfg_port_test.sv
`timescale 1ns/1ps
module clk_cfg_port_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, par_load_n = 1'b0;
  logic [8:0] par_m = 9'h1FF;
  logic [1:0] par_n = 2'b11;
  logic [8:0] m_div;
  logic [1:0] n_sel;
  logic [2:0] t_sel;
  logic       last_bit;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  clk_cfg_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .ser_load_i(ser_load), .par_load_n_i(par_load_n), .par_m_i(par_m), .par_n_i(par_n),
    .m_div_o(m_div), .n_sel_o(n_sel), .t_sel_o(t_sel), .last_bit_o(last_bit)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] out_word();
    return {t_sel, n_sel, m_div};
  endfunction

  // expected parallel view: t cleared, pins passed through
  function automatic logic [13:0] par_word(input logic [8:0] m, input logic [1:0] n);
    return {3'b000, n, m};
  endfunction

  task automatic ser_bit(input logic b);
    ser_data = b; wait_clk(4);
    ser_clk = 1'b1; wait_clk(4);
    ser_clk = 1'b0; wait_clk(4);
  endtask

  task automatic ser_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic ser_capture();
    ser_load = 1'b1; wait_clk(6);
    ser_load = 1'b0; wait_clk(6);
  endtask

  initial begin
    logic [13:0] w, w2, held;
    void'($urandom(32'd4242));
    // R8 reset state
    wait_clk(3);
    chk("R8 reset", {2'b0, out_word()}, {2'b0, 14'b000_11_111111111});
    rst_ni = 1'b1;
    // R4 parallel transparency, R9 latency
    par_m = 9'h0C8; par_n = 2'b00;
    wait_clk(4);
    chk("R9 latency", {2'b0, out_word()}, {2'b0, par_word(9'h0C8, 2'b00)});
    par_m = 9'h1DB; par_n = 2'b10; wait_clk(5);
    chk("R4 follow", {2'b0, out_word()}, {2'b0, par_word(9'h1DB, 2'b10)});
    par_load_n = 1'b1; wait_clk(5);
    par_m = 9'h055; par_n = 2'b01; wait_clk(6);
    chk("R4 hold", {2'b0, out_word()}, {2'b0, par_word(9'h1DB, 2'b10)});
    // R1/R2/R7 directed serial word
    w = {3'b101, 2'b01, 9'h133};
    ser_word(w);
    chk("R7 last bit", {15'b0, last_bit}, {15'b0, w[13]});
    chk("R3 closed before load", {2'b0, out_word()}, {2'b0, par_word(9'h1DB, 2'b10)});
    ser_load = 1'b1; wait_clk(6);
    chk("R3 transparent", {2'b0, out_word()}, {2'b0, w});
    ser_load = 1'b0; wait_clk(6);
    chk("R2 field order", {13'b0, t_sel}, {13'b0, 3'b101});
    // R3 hold after fall while shifting
    ser_word(14'h2AAA);
    chk("R3 hold", {2'b0, out_word()}, {2'b0, w});
    // R1 partial shift: two more bits
    ser_bit(1'b1); ser_bit(1'b0);
    chk("R1 shift", {15'b0, last_bit}, {15'b0, 1'b1});
    // R6 t cleared on parallel load
    par_m = 9'h1F0; par_n = 2'b11;
    par_load_n = 1'b0; wait_clk(6);
    chk("R6 t clear", {13'b0, t_sel}, 16'h0);
    chk("R4 reload", {2'b0, out_word()}, {2'b0, par_word(9'h1F0, 2'b11)});
    // R5 serial load ignored while parallel load low
    ser_word(14'h3FFF);
    ser_load = 1'b1; wait_clk(6);
    chk("R5 ignored open", {2'b0, out_word()}, {2'b0, par_word(9'h1F0, 2'b11)});
    ser_load = 1'b0; wait_clk(6);
    chk("R5 ignored after", {2'b0, out_word()}, {2'b0, par_word(9'h1F0, 2'b11)});
    par_load_n = 1'b1; wait_clk(6);
    // random serial words
    for (int k = 0; k < 20; k++) begin
      w2 = 14'($urandom);
      held = out_word();
      ser_word(w2);
      chk("R7 random last", {15'b0, last_bit}, {15'b0, w2[13]});
      chk("R3 random hold", {2'b0, out_word()}, {2'b0, held});
      ser_capture();
      chk("R2 random word", {2'b0, out_word()}, {2'b0, w2});
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule